// File: doc/BRIEF.md
# Memory Tag Check Unit

This block guards a modelled physical address range with lock-and-key tags. Memory is split into 16-byte granules, and each granule owns a 4-bit allocation tag held in an internal tag store. A pointer carries its own 4-bit key in address bits [59:56]. Every load or store request is checked by comparing that key with the tag of the granule it addresses. The outcome of a mismatch depends on a check-mode register. The unit can raise a fault on the response and block the access. It can let the access complete and set a sticky flag for software to find later. Or it can do nothing.

Besides checking, the unit runs the commands that manage tags. It can write a granule's tag, read a granule's tag back into a pointer, tag a granule while asking for its 16 data bytes to be cleared, and draw a random tag that avoids the values listed in an exclusion mask. The random tags come from a 16-bit LFSR. All requests use a valid/ready handshake. Each accepted request gets exactly one response on the following cycle.

Top module: `mtc_unit`

## Requirements
- R1: After reset all allocation tags are 0, the check mode is off (0), the sticky flag is 0, no response is valid, and req_ready is 1.
- R2: The granule index is taken from address bits [11:4] (NUM_GRAN=256, 16-byte granules). Bits [3:0] and the key field [59:56] do not select the granule.
- R3: Op 2 (set tag) writes req_data[59:56] into the addressed granule's tag. Op 3 (get tag) returns req_addr with bits [59:56] replaced by the stored tag and all other bits unchanged.
- R4: For op 0 (load) and op 1 (store), a key equal to the stored tag gives rsp_fault=0 and rsp_data equal to req_addr with bits [59:56] cleared, whatever the mode.
- R5: In mode 1 (sync), a mismatching load or store gives rsp_fault=1 and rsp_data=0, which means the access is blocked. The sticky flag is left unchanged.
- R6: In mode 2 (async), a mismatching load or store gives rsp_fault=0 and the R4 data, and async_flag is set in the same cycle as the response. The flag stays set until it is cleared.
- R7: In modes 0 and 3 (off), a mismatch raises no fault and does not touch the flag.
- R8: Op 6 (clear status) with req_data[0]=1 clears async_flag. With req_data[0]=0 the flag is left as it is.
- R9: Op 4 (zero and tag) writes req_data[59:56] as the granule's tag. Together with its response it pulses zero_strobe for one cycle, with zero_addr set to req_addr with bits [59:56] and [3:0] cleared.
- R10: Op 5 (random tag) returns req_addr with bits [59:56] replaced by a tag t for which req_data[t] is 0. req_data[15:0] is the exclusion mask.
- R11: When req_data[15:0] is 16'hFFFF, op 5 returns tag 0.
- R12: Each request accepted with req_valid and req_ready gives exactly one rsp_valid pulse on the next cycle. Back-to-back requests are served at one per cycle, and a write is visible to a request in the following cycle.
- R13: Op 7 (set mode) loads req_data[1:0] into the check mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit accepts a request this cycle |
| req_op | input | 3 | Operation code (0 load, 1 store, 2 set tag, 3 get tag, 4 zero and tag, 5 random tag, 6 clear status, 7 set mode) |
| req_addr | input | 64 | Tagged pointer; key in [59:56] |
| req_data | input | 64 | Operand: tag in [59:56], exclusion mask in [15:0], mode in [1:0], clear bit in [0] |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_fault | output | 1 | Synchronous tag fault; the access is blocked |
| rsp_data | output | 64 | Result address or pointer |
| zero_strobe | output | 1 | Request to clear the 16 data bytes of a granule |
| zero_addr | output | 64 | Aligned untagged address of the granule to clear |
| async_flag | output | 1 | Sticky deferred mismatch status |

## Verification
The bench goes after the granule aliasing boundary. It reaches one granule through pointers that differ only in key and offset bits. A design that took the key or the low bits into the index would return the wrong tag. It also switches between all four mode codes around the same mismatching pointer. A mode decode that was wrong would fault in async mode, or set the flag in sync or off mode. The sticky flag is tested against clear commands with the clear bit set and not set, and against later matching accesses that must not clear it. The random-tag command is driven with exclusion masks that leave one choice, none, or many, so a generator that ignored the mask or mishandled the all-excluded case returns a forbidden tag.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_SETTAG  = 3'd2,
    OP_GETTAG  = 3'd3,
    OP_ZEROTAG = 3'd4,
    OP_RANDTAG = 3'd5,
    OP_CLRSTAT = 3'd6,
    OP_SETMODE = 3'd7
  } mtc_op_e;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_ASYNC = 2'd2,
    MODE_OFF2  = 2'd3
  } chk_mode_e;

endpackage

// File: rtl/mtc_tag_store.sv
module mtc_tag_store #(
  parameter int DEPTH = 256,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);

  logic [DEPTH-1:0][TAG_W-1:0] tags;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [TAG_W-1:0] ent_q;
    logic [TAG_W-1:0] ent_d;
    logic             ent_en;

    always_comb begin
      ent_en = wr_en && (wr_idx == IDX_W'(g));
      ent_d  = ent_en ? wr_tag : ent_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end

    assign tags[g] = ent_q;
  end

  assign rd_tag = tags[rd_idx];

endmodule

// File: rtl/mtc_rand_gen.sv
module mtc_rand_gen #(
  parameter int          TAG_W  = 4,
  parameter int          LFSR_W = 16,
  parameter logic [15:0] POLY   = 16'hB400,
  parameter logic [15:0] SEED   = 16'hACE1,
  localparam int         NTAGS  = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [NTAGS-1:0] excl,
  output logic [TAG_W-1:0] tag_out
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;
  logic [TAG_W-1:0]  start;
  logic [TAG_W-1:0]  cand;
  logic [TAG_W-1:0]  pick;
  logic              found;

  // Galois LFSR, advanced only when a random tag is drawn
  always_comb begin
    lfsr_d = lfsr_q;
    if (step) begin
      lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? POLY[LFSR_W-1:0] : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED[LFSR_W-1:0];
    else        lfsr_q <= lfsr_d;
  end

  // Scan upward from the LFSR value for the first allowed tag
  always_comb begin
    start = lfsr_q[TAG_W-1:0];
    found = 1'b0;
    pick  = '0;
    cand  = '0;
    for (int k = 0; k < NTAGS; k++) begin
      cand = start + TAG_W'(k);
      if (!found && !excl[cand]) begin
        pick  = cand;
        found = 1'b1;
      end
    end
    tag_out = found ? pick : '0;
  end

  // R10
  rand_not_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !(&excl)) |-> !excl[tag_out]);

endmodule

// File: rtl/mtc_fault_policy.sv
module mtc_fault_policy
  import mtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_wdata,
  input  logic       chk_en,
  input  logic       mismatch,
  input  logic       clr_en,
  input  logic       clr_bit,
  output logic       block,
  output logic       async_flag
);

  chk_mode_e mode_q;
  chk_mode_e mode_d;
  logic      flag_q;
  logic      flag_d;
  logic      bad_acc;

  always_comb begin
    bad_acc = chk_en && mismatch;
    block   = bad_acc && (mode_q == MODE_SYNC);
  end

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = chk_mode_e'(mode_wdata);
  end

  always_comb begin
    flag_d = flag_q;
    if (clr_en && clr_bit)                  flag_d = 1'b0;
    if (bad_acc && (mode_q == MODE_ASYNC)) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      flag_q <= flag_d;
    end
  end

  assign async_flag = flag_q;

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(clr_en && clr_bit)) |=> flag_q);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_bit && !chk_en) |=> !flag_q);

  // R7
  off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_acc && (mode_q == MODE_OFF || mode_q == MODE_OFF2) && !flag_q) |=> !flag_q);

endmodule

// File: rtl/mtc_unit.sv
module mtc_unit
  import mtc_pkg::*;
#(
  parameter int          ADDR_W    = 64,
  parameter int          TAG_LSB   = 56,
  parameter int          TAG_W     = 4,
  parameter int          GRAN_LG2  = 4,
  parameter int          NUM_GRAN  = 256,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_data,
  output logic              zero_strobe,
  output logic [ADDR_W-1:0] zero_addr,
  output logic              async_flag
);

  localparam int IDX_W = $clog2(NUM_GRAN);
  localparam int NTAGS = 1 << TAG_W;

  function automatic logic [ADDR_W-1:0] put_tag(input logic [ADDR_W-1:0] a,
                                                input logic [TAG_W-1:0]  t);
    logic [ADDR_W-1:0] r;
    r = a;
    r[TAG_LSB +: TAG_W] = t;
    return r;
  endfunction

  mtc_op_e           op;
  logic              acc;
  logic              ready_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  key;
  logic [TAG_W-1:0]  stored;
  logic [TAG_W-1:0]  rtag;
  logic [ADDR_W-1:0] untag;
  logic              is_acc;
  logic              mismatch;
  logic              block;
  logic              tag_we;
  logic              rnd_step;
  logic              unused_bits;

  logic              rv_d, fault_d, zs_d;
  logic [ADDR_W-1:0] data_d, zaddr_d;
  logic              rv_q, fault_q, zs_q;
  logic [ADDR_W-1:0] data_q, zaddr_q;

  always_comb begin
    op       = mtc_op_e'(req_op);
    acc      = req_valid && ready_q;
    idx      = req_addr[GRAN_LG2 +: IDX_W];
    key      = req_addr[TAG_LSB +: TAG_W];
    untag    = put_tag(req_addr, '0);
    is_acc   = acc && (op == OP_LOAD || op == OP_STORE);
    mismatch = key != stored;
    tag_we   = acc && (op == OP_SETTAG || op == OP_ZEROTAG);
    rnd_step = acc && (op == OP_RANDTAG);
  end

  assign unused_bits = ^{req_data[ADDR_W-1:TAG_LSB+TAG_W], req_data[TAG_LSB-1:NTAGS]};

  mtc_tag_store #(.DEPTH(NUM_GRAN), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tag_we),
    .wr_idx (idx),
    .wr_tag (req_data[TAG_LSB +: TAG_W]),
    .rd_idx (idx),
    .rd_tag (stored)
  );

  mtc_rand_gen #(.TAG_W(TAG_W), .SEED(LFSR_SEED)) u_rand (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (rnd_step),
    .excl    (req_data[NTAGS-1:0]),
    .tag_out (rtag)
  );

  mtc_fault_policy u_policy (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (acc && op == OP_SETMODE),
    .mode_wdata (req_data[1:0]),
    .chk_en     (is_acc),
    .mismatch   (mismatch),
    .clr_en     (acc && op == OP_CLRSTAT),
    .clr_bit    (req_data[0]),
    .block      (block),
    .async_flag (async_flag)
  );

  // Response next-state
  always_comb begin
    rv_d    = acc;
    fault_d = block;
    zs_d    = acc && (op == OP_ZEROTAG);
    zaddr_d = zaddr_q;
    if (zs_d) zaddr_d = {untag[ADDR_W-1:GRAN_LG2], {GRAN_LG2{1'b0}}};
    data_d  = data_q;
    if (acc) begin
      unique case (op)
        OP_LOAD, OP_STORE: data_d = block ? '0 : untag;
        OP_GETTAG:         data_d = put_tag(req_addr, stored);
        OP_RANDTAG:        data_d = put_tag(req_addr, rtag);
        default:           data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      rv_q    <= 1'b0;
      fault_q <= 1'b0;
      zs_q    <= 1'b0;
      data_q  <= '0;
      zaddr_q <= '0;
    end else begin
      ready_q <= 1'b1;
      rv_q    <= rv_d;
      fault_q <= fault_d;
      zs_q    <= zs_d;
      data_q  <= data_d;
      zaddr_q <= zaddr_d;
    end
  end

  assign req_ready   = ready_q;
  assign rsp_valid   = rv_q;
  assign rsp_fault   = fault_q;
  assign rsp_data    = data_q;
  assign zero_strobe = zs_q;
  assign zero_addr   = zaddr_q;

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

  // R5
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_data == '0 && !zero_strobe));

  // R4
  fault_only_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> ($past(req_op) == OP_LOAD || $past(req_op) == OP_STORE));

  // R9
  zero_strobe_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_strobe |-> (rsp_valid && !rsp_fault && zero_addr[GRAN_LG2-1:0] == '0
                     && zero_addr[TAG_LSB +: TAG_W] == '0));

endmodule

// File: tb/sim_mtc_unit.sv
`timescale 1ns/1ps
module sim_mtc_unit;

  typedef struct {
    logic [63:0] exp_data;
    logic [63:0] dmask;
    logic [15:0] excl;
    logic        chk_excl;
    logic        exp_fault;
    logic        exp_flag;
    logic        exp_zs;
    logic [63:0] exp_zaddr;
    string       rq;
  } item_t;

  localparam logic [63:0] TMASK = 64'hF << 56;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [2:0]  req_op;
  logic [63:0] req_addr, req_data;
  logic        rsp_valid, rsp_fault, zero_strobe, async_flag;
  logic [63:0] rsp_data, zero_addr;

  int total = 0;
  int bad   = 0;
  item_t sb[$];

  logic [3:0] mtag [256];
  logic [1:0] mmode;
  logic       mflag;

  mtc_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data),
    .zero_strobe(zero_strobe), .zero_addr(zero_addr), .async_flag(async_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic note(input bit ok, input string rq, input logic [63:0] act,
                      input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Driver: computes the expected result from the requirements, then drives
  task automatic send(input logic [2:0] op, input logic [63:0] addr,
                      input logic [63:0] data, input string rq);
    item_t it;
    logic [7:0]  idx;
    logic [3:0]  st;
    logic [63:0] untag;
    idx   = addr[11:4];
    st    = mtag[idx];
    untag = addr & ~TMASK;
    it.exp_data = '0; it.dmask = '1; it.excl = '0; it.chk_excl = 1'b0;
    it.exp_fault = 1'b0; it.exp_zs = 1'b0; it.exp_zaddr = '0; it.rq = rq;
    case (op)
      3'd0, 3'd1: begin
        if (addr[59:56] != st && mmode == 2'd1) it.exp_fault = 1'b1;
        if (addr[59:56] != st && mmode == 2'd2) mflag = 1'b1;
        it.exp_data = it.exp_fault ? 64'd0 : untag;
      end
      3'd2: mtag[idx] = data[59:56];
      3'd3: it.exp_data = untag | ({60'd0, st} << 56);
      3'd4: begin
        mtag[idx] = data[59:56];
        it.exp_zs = 1'b1;
        it.exp_zaddr = untag & ~64'hF;
      end
      3'd5: begin
        it.exp_data = addr; it.dmask = ~TMASK;
        it.chk_excl = 1'b1; it.excl = data[15:0];
      end
      3'd6: if (data[0]) mflag = 1'b0;
      default: mmode = data[1:0];
    endcase
    it.exp_flag = mflag;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_data = data;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the expected item when a response appears
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        note(1'b0, "R12 unexpected response", rsp_data, 64'd0);
      end else begin
        automatic item_t it = sb.pop_front();
        automatic bit ok;
        automatic logic [3:0] t = rsp_data[59:56];
        ok = ((rsp_data & it.dmask) == (it.exp_data & it.dmask))
             && rsp_fault == it.exp_fault && async_flag == it.exp_flag
             && zero_strobe == it.exp_zs && (!it.exp_zs || zero_addr == it.exp_zaddr);
        if (it.chk_excl) begin
          if (&it.excl) ok = ok && (t == 4'd0);
          else          ok = ok && !it.excl[t];
        end
        if (!ok)
          $display("  detail %s fault=%b/%b flag=%b/%b zs=%b/%b zaddr=%h/%h",
                   it.rq, rsp_fault, it.exp_fault, async_flag, it.exp_flag,
                   zero_strobe, it.exp_zs, zero_addr, it.exp_zaddr);
        note(ok, it.rq, rsp_data, it.exp_data);
      end
    end else if (rst_n && zero_strobe) begin
      note(1'b0, "R9 strobe without response", zero_addr, 64'd0);
    end
  end

  bit timed_out = 1'b0;

  task automatic run_tests();
    // R1 reset state
    note(rsp_valid == 1'b0, "R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    note(async_flag == 1'b0, "R1 flag after reset", {63'd0, async_flag}, 64'd0);
    note(req_ready == 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
    send(3'd3, 64'h0000_0000_0000_0050, 0, "R1 tag zero after reset");
    send(3'd3, 64'h0F00_0000_0000_0FF0, 0, "R1 tag zero top granule");
    // R3 / R2 set, get, aliasing
    send(3'd2, 64'h0000_0000_0000_0050, 64'h0A00_0000_0000_0000, "R3 set tag");
    send(3'd3, 64'hF300_1234_5678_9050, 0, "R3 get tag keeps other bits");
    send(3'd3, 64'h0C00_0000_0000_005F, 0, "R2 alias via offset and key");
    send(3'd3, 64'h0000_0000_0000_1050, 0, "R2 index wraps above bit 11");
    send(3'd3, 64'h0000_0000_0000_0060, 0, "R2 neighbour granule untouched");
    // R7 mode off at reset
    send(3'd0, 64'h0100_0000_0000_0054, 0, "R7 mismatch in off mode");
    // R13 / R4 / R5 sync
    send(3'd7, 0, 64'd1, "R13 set mode sync");
    send(3'd0, 64'h0A00_0000_ABCD_0058, 0, "R4 matching load");
    send(3'd1, 64'h0B00_0000_0000_0050, 0, "R5 sync mismatching store");
    send(3'd0, 64'h0000_0000_0000_0050, 0, "R5 sync untagged pointer");
    // R6 async
    send(3'd7, 0, 64'd2, "R13 set mode async");
    send(3'd0, 64'h0500_0000_0000_0050, 0, "R6 async mismatch sets flag");
    send(3'd1, 64'h0A00_0000_0000_0050, 0, "R6 flag stays on matching store");
    // R8 clear
    send(3'd6, 0, 64'd0, "R8 clear bit low keeps flag");
    send(3'd6, 0, 64'd1, "R8 clear bit high");
    send(3'd0, 64'h0A00_0000_0000_0050, 0, "R8 flag stays clear on match");
    // R7 mode 3
    send(3'd7, 0, 64'd3, "R13 set mode 3");
    send(3'd1, 64'h0200_0000_0000_0050, 0, "R7 mode 3 ignores mismatch");
    // R9 zero and tag
    send(3'd4, 64'h0700_0000_0000_0A3C, 64'h0600_0000_0000_0000, "R9 zero and tag");
    send(3'd3, 64'h0000_0000_0000_0A30, 0, "R9 tag written by zero op");
    send(3'd7, 0, 64'd1, "R13 back to sync");
    send(3'd0, 64'h0600_0000_0000_0A38, 0, "R9 access matches new tag");
    // R10 / R11 random tags
    send(3'd5, 64'h0300_0000_1234_0000, 64'd0, "R10 no exclusion");
    send(3'd5, 64'h0300_0000_1234_0000, 64'h7FFF, "R10 only tag 15 allowed");
    send(3'd5, 64'h0300_0000_1234_0000, 64'hFFFE, "R10 only tag 0 allowed");
    send(3'd5, 64'hF300_0000_0000_0010, 64'hFFFF, "R11 all excluded gives 0");
    for (int i = 0; i < 24; i++) begin
      logic [15:0] m;
      m = 16'hA5A5 ^ (16'h1357 * i[15:0]);
      if (m == 16'hFFFF) m = 16'hFF7F;
      send(3'd5, 64'h0000_0000_0000_0100 + 64'(i) * 16, {48'd0, m}, "R10 mask sweep");
    end
    idle(3);
    // R12 back-to-back write then read over all granules
    for (int g = 0; g < 256; g++) begin
      send(3'd2, 64'(g) << 4, {4'd0, 4'(g ^ 3), 56'd0}, "R12 stream set");
      send(3'd3, (64'(g) << 4) | 64'h5, 0, "R12 stream get");
    end
    send(3'd0, (64'd77 << 4) | ({60'd0, 4'(77 ^ 3)} << 56), 0, "R12 stream check match");
    send(3'd1, (64'd78 << 4), 0, "R12 stream check mismatch");
    idle(6);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mtag[i] = 4'd0;
    mmode = 2'd0; mflag = 1'b0;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) note(1'b0, "R12 watchdog expired", 64'd0, 64'd1);
    if (sb.size() != 0) note(1'b0, "R12 missing responses", 64'(sb.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule